// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block keeps the byte count for a storage controller's DMA data phase. Software programs a 24-bit count one byte at a time into a set of shadow registers. Any command issued with its DMA bit set copies the shadow bytes into the working count. A transfer command then turns the working count into a burst length. It clips that length against how much data the device still expects, or against the command buffer when a command phase is pending.

While the DMA engine moves data, each beat reports how many bytes it carried. The block counts the remaining bytes down. It finishes the burst by direction. A read toward memory finishes as soon as its bytes are gone, or early when the device runs dry. A write toward the device waits for the device to report that it is done. On finishing, the block raises terminal count, clears the working count and gives a one-cycle completion pulse that serves as the interrupt request.

The controller has three states. In `ST_IDLE` no burst is active. In `ST_RUN` beats are counting down. In `ST_WAIT` the count is spent or empty and the device has not yet reported done. The transitions are:
- start (IDLE/RUN/WAIT to RUN, or to WAIT on a zero length);
- drain-read (RUN to IDLE);
- drain-write (RUN to WAIT);
- early-read (RUN to IDLE);
- device-done (RUN/WAIT to IDLE).

Top module: `dma_len_ctr`

## Requirements
- R1: After reset the working count, burst length and remaining length are zero, terminal count is low, the block is idle and no completion pulse is given.
- R2: Host byte writes (select 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16) change only the shadow count. A command with the DMA bit set copies the shadow count into the working count. A command without it leaves the working count unchanged.
- R3: A transfer command forms its count from the three bytes in the order above. It uses the shadow count when the same command carries the DMA bit and the working count otherwise. A count of zero stands for 65536 bytes.
- R4: Outside a command phase, the burst length is the smaller of the count and the magnitude of the signed device size. A negative size means host-to-device (write), and zero or positive means device-to-host (read).
- R5: With a command phase pending, the burst length is the smaller of the count and 32, and the direction is write.
- R6: Terminal count is cleared by a transfer command and by a host write to any count byte.
- R7: Each beat lowers the remaining length by its byte count, saturating at zero.
- R8: In a read, the burst completes in the cycle its remaining length reaches zero. In a write, reaching zero moves to the wait state, and completion waits for device-done.
- R9: In a read, device-empty completes the burst while the remaining length is still nonzero.
- R10: Completion gives a one-cycle pulse, sets terminal count, and zeroes the working count and the remaining length. It leaves the shadow count and the burst length as they were.
- R11: A burst length of zero goes straight to the wait state and completes only on device-done.
- R12: Device-done completes a burst in the run or wait state and has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Host write strobe for a shadow count byte |
| cnt_wr_sel | input | 2 | Byte select: 0 low, 1 middle, 2 high |
| cnt_wr_data | input | 8 | Byte written |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | Command carries the DMA bit |
| cmd_xfer | input | 1 | Command is a transfer command |
| cmd_phase | input | 1 | Command-phase bytes pending |
| dev_remain | input | 24 | Signed remaining device size; negative means write |
| beat_valid | input | 1 | DMA beat strobe |
| beat_bytes | input | 8 | Bytes moved by this beat |
| dev_empty | input | 1 | Device holds no more data for the current read |
| dev_done | input | 1 | Device finished the command |
| burst_len | output | 25 | Length of the current burst |
| remain_len | output | 25 | Bytes left in the burst |
| done_pulse | output | 1 | One-cycle completion and interrupt request |
| tc_flag | output | 1 | Terminal-count status |
| busy | output | 1 | Burst active (run or wait state) |
| live_cnt | output | 24 | Working count for read-back |

## Verification
The write-direction wait is the hardest case to reach from the ports. The remaining length must be seen at zero with no completion pulse, then released only by device-done. The stimulus reaches it with a negative device size smaller than the programmed count. Two beats then drain it, and the second one overshoots to exercise saturation. The zero-length burst needs a device size of zero and is probed the same way. A scoreboard also rejects any completion pulse that no command led it to expect, which covers device-done arriving while idle.

// File: rtl/dma_len_pkg.sv
package dma_len_pkg;
    localparam int ZERO_COUNT_LEN = 65536;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/dma_cnt_regs.sv
module dma_cnt_regs #(
    parameter int NBYTES = 3,
    localparam int CW    = 8 * NBYTES,
    localparam int SELW  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [7:0]      wr_data,
    input  logic            load,
    input  logic            start,
    input  logic            finish,
    output logic [CW-1:0]   shadow_cnt,
    output logic [CW-1:0]   live_cnt,
    output logic            tc_flag
);
    logic host_cnt_wr;
    assign host_cnt_wr = wr_en && ({1'b0, wr_sel} < (SELW+1)'(NBYTES));

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_cnt[8*g +: 8] <= 8'h00;
            end else if (wr_en && wr_sel == SELW'(g)) begin
                shadow_cnt[8*g +: 8] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_cnt[8*g +: 8] <= 8'h00;
            end else if (load) begin
                live_cnt[8*g +: 8] <= shadow_cnt[8*g +: 8];
            end else if (finish) begin
                live_cnt[8*g +: 8] <= 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_flag <= 1'b0;
        end else if (start) begin
            tc_flag <= 1'b0;
        end else if (finish) begin
            tc_flag <= 1'b1;
        end else if (host_cnt_wr) begin
            tc_flag <= 1'b0;
        end
    end

    // R2
    load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> live_cnt == $past(shadow_cnt));

    // R6
    start_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !tc_flag);
endmodule

// File: rtl/dma_len_calc.sv
module dma_len_calc #(
    parameter int CW      = 24,
    parameter int SW      = 24,
    parameter int CMD_CAP = 32,
    localparam int LW     = CW + 1
) (
    input  logic [CW-1:0] cnt,
    input  logic [SW-1:0] dev_size,
    input  logic          cmd_phase,
    output logic [LW-1:0] len,
    output logic          to_dev
);
    import dma_len_pkg::*;

    logic [LW-1:0] base_len;
    logic [SW:0]   size_ext;
    logic [SW:0]   size_mag;
    logic [LW-1:0] limit;

    always_comb begin
        base_len = (cnt == '0) ? LW'(ZERO_COUNT_LEN) : LW'(cnt);
        size_ext = {dev_size[SW-1], dev_size};
        size_mag = size_ext[SW] ? (~size_ext + 1'b1) : size_ext;
        limit    = cmd_phase ? LW'(CMD_CAP) : LW'(size_mag);
        len      = (base_len < limit) ? base_len : limit;
        to_dev   = cmd_phase | dev_size[SW-1];
    end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm #(
    parameter int LW = 25,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] start_len,
    input  logic          start_to_dev,
    input  logic          beat_valid,
    input  logic [BW-1:0] beat_bytes,
    input  logic          dev_empty,
    input  logic          dev_done,
    output logic          finish,
    output logic          done_pulse,
    output logic [LW-1:0] remain_len,
    output logic [LW-1:0] burst_len,
    output logic          busy
);
    import dma_len_pkg::*;

    xfer_state_t   state, nxt_state;
    logic [LW-1:0] nxt_remain;
    logic [LW-1:0] drained;
    logic          dir_to_dev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            remain_len <= '0;
            burst_len  <= '0;
            dir_to_dev <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            state      <= nxt_state;
            remain_len <= nxt_remain;
            done_pulse <= finish;
            if (start) begin
                burst_len  <= start_len;
                dir_to_dev <= start_to_dev;
            end
        end
    end

    always_comb begin
        nxt_state  = state;
        nxt_remain = remain_len;
        finish     = 1'b0;
        drained    = remain_len;
        if (beat_valid) begin
            drained = (remain_len > LW'(beat_bytes)) ? remain_len - LW'(beat_bytes) : '0;
        end
        if (start) begin
            nxt_remain = start_len;
            nxt_state  = (start_len == '0) ? ST_WAIT : ST_RUN;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_RUN: begin
                    nxt_remain = drained;
                    if (dev_done) begin
                        finish = 1'b1;
                    end else if (drained == '0) begin
                        if (dir_to_dev) nxt_state = ST_WAIT;
                        else            finish    = 1'b1;
                    end else if (!dir_to_dev && dev_empty) begin
                        finish = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (dev_done) finish = 1'b1;
                end
                default: nxt_state = ST_IDLE;
            endcase
            if (finish) begin
                nxt_state  = ST_IDLE;
                nxt_remain = '0;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    // R7
    remain_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> remain_len <= $past(remain_len));

    // R8
    write_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !dev_done && !start) |=> (state == ST_WAIT && !done_pulse));

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> !done_pulse);
endmodule

// File: rtl/dma_len_ctr.sv
module dma_len_ctr #(
    parameter int NBYTES  = 3,
    parameter int SW      = 24,
    parameter int BW      = 8,
    parameter int CMD_CAP = 32,
    localparam int CW     = 8 * NBYTES,
    localparam int LW     = CW + 1,
    localparam int SELW   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_wr_en,
    input  logic [SELW-1:0] cnt_wr_sel,
    input  logic [7:0]      cnt_wr_data,
    input  logic            cmd_valid,
    input  logic            cmd_dma,
    input  logic            cmd_xfer,
    input  logic            cmd_phase,
    input  logic [SW-1:0]   dev_remain,
    input  logic            beat_valid,
    input  logic [BW-1:0]   beat_bytes,
    input  logic            dev_empty,
    input  logic            dev_done,
    output logic [LW-1:0]   burst_len,
    output logic [LW-1:0]   remain_len,
    output logic            done_pulse,
    output logic            tc_flag,
    output logic            busy,
    output logic [CW-1:0]   live_cnt
);
    logic          start, load, finish, to_dev;
    logic [CW-1:0] shadow_cnt, eff_cnt;
    logic [LW-1:0] calc_len;

    assign start   = cmd_valid & cmd_xfer;
    assign load    = cmd_valid & cmd_dma;
    assign eff_cnt = cmd_dma ? shadow_cnt : live_cnt;

    dma_cnt_regs #(.NBYTES(NBYTES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cnt_wr_en),
        .wr_sel     (cnt_wr_sel),
        .wr_data    (cnt_wr_data),
        .load       (load),
        .start      (start),
        .finish     (finish),
        .shadow_cnt (shadow_cnt),
        .live_cnt   (live_cnt),
        .tc_flag    (tc_flag)
    );

    dma_len_calc #(.CW(CW), .SW(SW), .CMD_CAP(CMD_CAP)) u_calc (
        .cnt       (eff_cnt),
        .dev_size  (dev_remain),
        .cmd_phase (cmd_phase),
        .len       (calc_len),
        .to_dev    (to_dev)
    );

    dma_xfer_fsm #(.LW(LW), .BW(BW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_len    (calc_len),
        .start_to_dev (to_dev),
        .beat_valid   (beat_valid),
        .beat_bytes   (beat_bytes),
        .dev_empty    (dev_empty),
        .dev_done     (dev_done),
        .finish       (finish),
        .done_pulse   (done_pulse),
        .remain_len   (remain_len),
        .burst_len    (burst_len),
        .busy         (busy)
    );

    // R10
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (tc_flag && remain_len == '0 && live_cnt == '0 && !busy));

    // R5
    cmd_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cmd_phase) |=> burst_len <= LW'(CMD_CAP));
endmodule

// File: tb/dma_len_ctr_bench.sv
`timescale 1ns/1ps
module dma_len_ctr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [1:0]  cnt_wr_sel = '0;
    logic [7:0]  cnt_wr_data = '0;
    logic        cmd_valid = 1'b0, cmd_dma = 1'b0, cmd_xfer = 1'b0, cmd_phase = 1'b0;
    logic [23:0] dev_remain = '0;
    logic        beat_valid = 1'b0;
    logic [7:0]  beat_bytes = '0;
    logic        dev_empty = 1'b0, dev_done = 1'b0;
    logic [24:0] burst_len, remain_len;
    logic        done_pulse, tc_flag, busy;
    logic [23:0] live_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    int unsigned exp_q[$];

    always #2.5 clk = ~clk;

    dma_len_ctr u_dma_len_ctr (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel), .cnt_wr_data(cnt_wr_data),
        .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer), .cmd_phase(cmd_phase),
        .dev_remain(dev_remain), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
        .dev_empty(dev_empty), .dev_done(dev_done),
        .burst_len(burst_len), .remain_len(remain_len), .done_pulse(done_pulse),
        .tc_flag(tc_flag), .busy(busy), .live_cnt(live_cnt)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input int sel, input logic [7:0] d);
        cnt_wr_en = 1'b1; cnt_wr_sel = sel[1:0]; cnt_wr_data = d;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic set_shadow(input int val);
        wr_byte(0, val[7:0]);
        wr_byte(1, val[15:8]);
        wr_byte(2, val[23:16]);
    endtask

    task automatic issue(input bit dma, input bit xfer, input bit cph, input int sz);
        cmd_valid = 1'b1; cmd_dma = dma; cmd_xfer = xfer; cmd_phase = cph;
        dev_remain = sz[23:0];
        @(negedge clk);
        cmd_valid = 1'b0; cmd_dma = 1'b0; cmd_xfer = 1'b0; cmd_phase = 1'b0;
    endtask

    task automatic beat(input int nb, input bit empty);
        beat_valid = 1'b1; beat_bytes = nb[7:0]; dev_empty = empty;
        @(negedge clk);
        beat_valid = 1'b0; dev_empty = 1'b0;
    endtask

    task automatic pulse_done();
        dev_done = 1'b1;
        @(negedge clk);
        dev_done = 1'b0;
    endtask

    // Scoreboard monitor: each completion pulse must match a queued burst length
    always @(negedge clk) begin
        if (rst_n && done_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected completion", 1, 0);
            end else begin
                automatic int unsigned e = exp_q.pop_front();
                chk(burst_len == 25'(e), "R10 burst length kept at completion", burst_len, e);
                chk(tc_flag == 1'b1, "R10 terminal count set", tc_flag, 1);
                chk(live_cnt == '0, "R10 working count zeroed", live_cnt, 0);
                chk(remain_len == '0, "R10 remaining zeroed", remain_len, 0);
            end
        end
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(live_cnt == 0 && burst_len == 0 && remain_len == 0, "R1 counts zero", live_cnt, 0);
        chk(!tc_flag && !busy && !done_pulse, "R1 flags low", {tc_flag, busy, done_pulse}, 0);

        // R2 shadow writes and reload
        set_shadow(24'h001234);
        chk(live_cnt == 0, "R2 host write leaves working count", live_cnt, 0);
        issue(1'b0, 1'b0, 1'b0, 0);
        chk(live_cnt == 0, "R2 non-DMA command no reload", live_cnt, 0);
        issue(1'b1, 1'b0, 1'b0, 0);
        chk(live_cnt == 24'h001234, "R2 DMA command reloads", live_cnt, 24'h001234);

        // R3 working count used, R9 early read completion
        exp_q.push_back(32'h1234);
        issue(1'b0, 1'b1, 1'b0, 32'h100000);
        chk(burst_len == 25'h1234, "R3 length from working count", burst_len, 25'h1234);
        chk(busy && remain_len == 25'h1234, "R7 remaining loaded", remain_len, 25'h1234);
        beat(200, 1'b1);
        chk(done_pulse, "R9 early read completion", done_pulse, 1);
        @(negedge clk);
        issue(1'b1, 1'b0, 1'b0, 0);
        chk(live_cnt == 24'h001234, "R10 shadow kept after completion", live_cnt, 24'h001234);

        // R3 zero count means 65536, R6 start clears tc
        set_shadow(0);
        exp_q.push_back(65536);
        issue(1'b1, 1'b1, 1'b0, 32'h20000);
        chk(burst_len == 25'h10000, "R3 zero count is 65536", burst_len, 25'h10000);
        chk(!tc_flag, "R6 transfer start clears tc", tc_flag, 0);
        pulse_done();
        chk(done_pulse, "R12 device-done completes run", done_pulse, 1);
        @(negedge clk);

        // R6 host write clears tc
        chk(tc_flag, "R6 tc held before write", tc_flag, 1);
        wr_byte(1, 8'h05);
        chk(!tc_flag, "R6 host write clears tc", tc_flag, 0);

        // R4 clip by negative size, R7 saturation, R8 write waits
        set_shadow(24'h000500);
        exp_q.push_back(40);
        issue(1'b1, 1'b1, 1'b0, -40);
        chk(burst_len == 25'd40, "R4 clip to device size", burst_len, 40);
        beat(30, 1'b0);
        chk(remain_len == 25'd10, "R7 beat decrements", remain_len, 10);
        beat(25, 1'b0);
        chk(remain_len == 0, "R7 saturates at zero", remain_len, 0);
        chk(busy && !done_pulse, "R8 write waits for device", {busy, done_pulse}, 2);
        @(negedge clk);
        chk(busy && !done_pulse, "R8 write still waiting", {busy, done_pulse}, 2);
        pulse_done();
        chk(done_pulse, "R8 write completes on device-done", done_pulse, 1);
        @(negedge clk);

        // R8 read completes on drain
        exp_q.push_back(20);
        issue(1'b1, 1'b1, 1'b0, 20);
        chk(burst_len == 25'd20, "R4 read clip", burst_len, 20);
        beat(20, 1'b0);
        chk(done_pulse, "R8 read completes at zero", done_pulse, 1);
        @(negedge clk);

        // R5 command phase cap
        exp_q.push_back(32);
        issue(1'b1, 1'b1, 1'b1, 32'h1000);
        chk(burst_len == 25'd32, "R5 command buffer cap", burst_len, 32);
        beat(32, 1'b0);
        chk(busy && !done_pulse, "R5 command phase is write", {busy, done_pulse}, 2);
        pulse_done();
        @(negedge clk);

        // R11 zero-length burst
        exp_q.push_back(0);
        issue(1'b1, 1'b1, 1'b0, 0);
        chk(burst_len == 0 && busy, "R11 zero length waits", burst_len, 0);
        beat(8, 1'b1);
        repeat (2) @(negedge clk);
        chk(busy && !done_pulse, "R11 no completion without device", {busy, done_pulse}, 2);
        pulse_done();
        chk(done_pulse, "R11 device-done completes", done_pulse, 1);
        @(negedge clk);

        // R12 device-done while idle
        pulse_done();
        chk(!done_pulse && !tc_flag == 1'b0, "R12 idle device-done ignored", done_pulse, 0);
        @(negedge clk);

        // R3 byte order
        set_shadow(24'h030201);
        issue(1'b1, 1'b0, 1'b0, 0);
        chk(live_cnt == 24'h030201, "R2 byte placement", live_cnt, 24'h030201);
        exp_q.push_back(32'h030201);
        issue(1'b0, 1'b1, 1'b0, 32'h7FFFFF);
        chk(burst_len == 25'h030201, "R3 byte order", burst_len, 25'h030201);
        pulse_done();
        @(negedge clk);

        chk(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule